// File: doc/BRIEF.md
# Indexed Bit-Shift Read-Modify-Write Unit

This unit carries out the indexed shift and bit-manipulation instruction group of an 8-bit CPU. It runs after the index prefix and the escape byte have been consumed. Two bytes arrive on a byte stream: first a signed displacement, then the operation byte. The unit adds the displacement to the 16-bit index value and reads one memory byte at that address. It applies the selected rotate, shift, bit test, bit clear or bit set to that byte.

Every modifying operation writes its result back to the addressed byte. The same result can also be copied to a general register selected by the low three bits of the operation byte. A bit test only updates flags. Operation bytes that fall in the test range but do not name memory are rejected without any memory access.

The memory port is synchronous. The unit raises a read strobe for one cycle with the address. The bench memory returns the data on `mem_rdata` in the following cycle.

Top module: `idx_bitop_rmw`

## Requirements
- R1: While idle, the first byte accepted (`in_valid` high at a rising edge) is the displacement and the second is the operation byte. `idx_val` and `flags_in` are sampled together with the operation byte. `mem_rd` is high for exactly the one cycle that follows acceptance of the operation byte.
- R2: `mem_addr` during the read and the write equals `idx_val` plus the sign-extended displacement, modulo 2^16.
- R3: For operation bytes 0x00-0x3F, bits [5:3] pick the shift as follows: 0 rotate left circular, 1 rotate right circular, 2 rotate left through carry (old carry into bit 0), 3 rotate right through carry (old carry into bit 7), 4 arithmetic left (0 into bit 0), 5 arithmetic right (bit 7 kept), 7 logical right (0 into bit 7).
- R4: Shift code 6 shifts left and fills bit 0 with 1.
- R5: After a shift, the flag byte is {S,Z,0,H,0,P,N,C} from bit 7 down to bit 0. S is result bit 7, Z means the result is zero, P means the result has an even number of ones, H=0, N=0, C is the bit shifted out, and bits 5 and 3 are 0. `flags_we` is high in the write cycle.
- R6: Operation bytes 0x80-0xBF clear bit op[5:3] of the byte and 0xC0-0xFF set it. These leave the flags untouched (`flags_we` stays low).
- R7: For every shift, clear and set, `mem_wr` is high for one cycle, two cycles after `mem_rd`, at the same address. `mem_wdata` holds the result.
- R8: In the write cycle, `rf_sel` carries op[2:0] (0 B, 1 C, 2 D, 3 E, 4 H, 5 L, 6 none, 7 A) and `rf_data` carries the result. `rf_we` accompanies `mem_wr` unless op[2:0] is 6.
- R9: Operation bytes 0x40-0x7F with op[2:0]=6 test bit op[5:3]. No write is made. Two cycles after the read, `flags_we` pulses with flags {fin[7], Z, fin[5], 1, fin[3], fin[2], 0, fin[0]}, where Z is set when the bit is 0 and fin is the sampled `flags_in`.
- R10: Operation bytes 0x40-0x7F with op[2:0] not equal to 6 raise `invalid` for the one cycle after acceptance. They produce no read, write, register write, flag write or done.
- R11: `done` pulses for one cycle in the cycle after the write cycle, or after the flag cycle of a bit test.
- R12: During and right after reset, all strobes (`mem_rd`, `mem_wr`, `rf_we`, `flags_we`, `done`, `invalid`) are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Instruction byte present |
| in_byte | input | 8 | Displacement, then operation byte |
| idx_val | input | 16 | Index register value |
| flags_in | input | 8 | Current flag byte |
| mem_addr | output | 16 | Effective address |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid the cycle after `mem_rd` |
| rf_we | output | 1 | Register copy strobe |
| rf_sel | output | 3 | Register copy target |
| rf_data | output | 8 | Register copy data |
| flags_we | output | 1 | Flag update strobe |
| flags_out | output | 8 | New flag byte |
| done | output | 1 | Instruction complete |
| invalid | output | 1 | Operation byte rejected |

## Verification
Counting from the edge that accepts the operation byte, results fall due in fixed cycles. The read strobe or the invalid pulse appears in the first cycle after that edge. Nothing is driven in the second cycle while the data returns. The write, register copy and flag update appear in the third cycle, and `done` in the fourth. For each instruction, the bench's behavioural model builds the expected strobe vector for each of these cycles plus one idle cycle after them. Each cycle is sampled at the falling edge, and the address, write data, register target and flags are compared only in the cycle where they are due.

// File: rtl/idx_bitop_rmw.sv
module idx_bitop_rmw #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [DW-1:0] in_byte,
  input  logic [AW-1:0] idx_val,
  input  logic [DW-1:0] flags_in,
  output logic [AW-1:0] mem_addr,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          rf_we,
  output logic [2:0]    rf_sel,
  output logic [DW-1:0] rf_data,
  output logic          flags_we,
  output logic [DW-1:0] flags_out,
  output logic          done,
  output logic          invalid
);
  typedef enum logic [2:0] {S_IDLE, S_OP, S_RD, S_EX, S_WR, S_FL, S_DN} st_t;
  st_t st;
  logic [DW-1:0] disp_q, op_q, fin_q, res_q, fl_q;
  logic [AW-1:0] ea;
  logic          inv_q;

  wire op_bad = in_byte[7:6] == 2'b01 && in_byte[2:0] != 3'd6;
  wire [1:0] grp = op_q[7:6];
  wire [2:0] bn  = op_q[5:3];
  wire [DW-1:0] v = mem_rdata;
  wire [DW-1:0] mask = DW'(1) << bn;

  logic [DW-1:0] sh_res, nres, nfl;
  logic          sh_c;

  always_comb begin
    case (bn)
      3'd0: {sh_c, sh_res} = {v[7], v[6:0], v[7]};
      3'd1: {sh_c, sh_res} = {v[0], v[0], v[7:1]};
      3'd2: {sh_c, sh_res} = {v[7], v[6:0], fin_q[0]};
      3'd3: {sh_c, sh_res} = {v[0], fin_q[0], v[7:1]};
      3'd4: {sh_c, sh_res} = {v[7], v[6:0], 1'b0};
      3'd5: {sh_c, sh_res} = {v[0], v[7], v[7:1]};
      3'd6: {sh_c, sh_res} = {v[7], v[6:0], 1'b1};
      default: {sh_c, sh_res} = {v[0], 1'b0, v[7:1]};
    endcase
    case (grp)
      2'b00: nres = sh_res;
      2'b10: nres = v & ~mask;
      2'b11: nres = v | mask;
      default: nres = v;
    endcase
    if (grp == 2'b01)
      nfl = {fin_q[7], ~|(v & mask), fin_q[5], 1'b1, fin_q[3], fin_q[2], 1'b0, fin_q[0]};
    else
      nfl = {sh_res[7], ~|sh_res, 3'b000, ~^sh_res, 1'b0, sh_c};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; disp_q <= '0; op_q <= '0; fin_q <= '0;
      res_q <= '0; fl_q <= '0; ea <= '0; inv_q <= 1'b0;
    end else begin
      inv_q <= 1'b0;
      case (st)
        S_IDLE: if (in_valid) begin disp_q <= in_byte; st <= S_OP; end
        S_OP: if (in_valid) begin
          op_q  <= in_byte;
          fin_q <= flags_in;
          ea    <= idx_val + {{(AW-DW){disp_q[DW-1]}}, disp_q};
          if (op_bad) begin inv_q <= 1'b1; st <= S_IDLE; end
          else st <= S_RD;
        end
        S_RD: st <= S_EX;
        S_EX: begin
          res_q <= nres;
          fl_q  <= nfl;
          st    <= (grp == 2'b01) ? S_FL : S_WR;
        end
        S_WR, S_FL: st <= S_DN;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign mem_addr  = ea;
  assign mem_rd    = st == S_RD;
  assign mem_wr    = st == S_WR;
  assign mem_wdata = res_q;
  assign rf_sel    = op_q[2:0];
  assign rf_data   = res_q;
  assign rf_we     = mem_wr && op_q[2:0] != 3'd6;
  assign flags_we  = (mem_wr && grp == 2'b00) || st == S_FL;
  assign flags_out = fl_q;
  assign done      = st == S_DN;
  assign invalid   = inv_q;

  assert_wr_after_rd_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> $past(mem_rd, 2) && mem_addr == $past(mem_addr, 2));
  assert_no_access_after_bad_R10: assert property (@(posedge clk) disable iff (!rst_n)
    invalid |-> !mem_rd && !mem_wr && !flags_we && !done);
  assert_done_follows_commit_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(mem_wr || flags_we));
  assert_rf_only_with_mem_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> mem_wr && rf_sel != 3'd6);
  assert_one_strobe_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_rd, mem_wr, done, invalid}));
  assert_rd_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> !mem_rd);
endmodule

// File: tb/test_idx_bitop_rmw.sv
module test_idx_bitop_rmw;
  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [7:0] in_byte = '0, flags_in = '0, mem_rdata, mem_wdata, rf_data, flags_out;
  logic [15:0] idx_val = '0, mem_addr;
  logic mem_rd, mem_wr, rf_we, flags_we, done, invalid;
  logic [2:0] rf_sel;
  logic [7:0] mem [0:255];
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  idx_bitop_rmw i_idx_bitop_rmw (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
    .idx_val(idx_val), .flags_in(flags_in), .mem_addr(mem_addr),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .rf_we(rf_we), .rf_sel(rf_sel),
    .rf_data(rf_data), .flags_we(flags_we), .flags_out(flags_out),
    .done(done), .invalid(invalid));

  always_ff @(posedge clk) begin
    if (mem_rd) mem_rdata <= mem[mem_addr[7:0]];
    if (mem_wr) mem[mem_addr[7:0]] <= mem_wdata;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic even_par(input logic [7:0] x);
    int n = 0;
    for (int i = 0; i < 8; i++) n += x[i];
    return (n % 2) == 0;
  endfunction

  // behavioural reference: result, flags and the class of instruction
  task automatic model(input logic [7:0] op, input logic [7:0] val, input logic [7:0] fin,
                       output logic [7:0] res, output logic [7:0] fl,
                       output bit bad, output bit test, output bit setfl);
    int kind = op / 64;
    int b = (op / 8) % 8;
    int c = 0;
    res = val; fl = fin; bad = 0; test = 0; setfl = 0;
    if (kind == 1) begin
      if (op % 8 != 6) begin bad = 1; return; end
      test = 1; setfl = 1;
      fl = fin;
      fl[6] = ((val >> b) & 1) == 0;
      fl[4] = 1; fl[1] = 0;
    end else if (kind == 2) res = val & ~(8'd1 << b);
    else if (kind == 3) res = val | (8'd1 << b);
    else begin
      setfl = 1;
      case (b)
        0: begin c = val[7]; res = {val[6:0], val[7]}; end
        1: begin c = val[0]; res = {val[0], val[7:1]}; end
        2: begin c = val[7]; res = {val[6:0], fin[0]}; end
        3: begin c = val[0]; res = {fin[0], val[7:1]}; end
        4: begin c = val[7]; res = val << 1; end
        5: begin c = val[0]; res = {val[7], val[7:1]}; end
        6: begin c = val[7]; res = (val << 1) | 8'd1; end
        default: begin c = val[0]; res = val >> 1; end
      endcase
      fl = 8'h00;
      fl[7] = res[7]; fl[6] = (res == 0); fl[2] = even_par(res); fl[0] = c[0];
    end
  endtask

  task automatic run(input string req, input logic [15:0] idx, input logic [7:0] disp,
                     input logic [7:0] op, input logic [7:0] fin, input logic [7:0] val);
    logic [7:0] res, fl; bit bad, test, setfl;
    logic [15:0] ea = idx + {{8{disp[7]}}, disp};
    logic [5:0] exp_v [0:4];
    model(op, val, fin, res, fl, bad, test, setfl);
    mem[ea[7:0]] = val;
    exp_v[0] = bad ? 6'b000001 : 6'b100000;
    exp_v[1] = 6'b0;
    exp_v[2] = bad ? 6'b0 : {1'b0, !test, !test && op[2:0] != 3'd6, setfl, 2'b00};
    exp_v[3] = bad ? 6'b0 : 6'b000010;
    exp_v[4] = 6'b0;
    @(negedge clk); in_valid = 1; in_byte = disp;
    @(negedge clk); in_byte = op; idx_val = idx; flags_in = fin;
    @(negedge clk); in_valid = 0; in_byte = 8'hxx; idx_val = 16'hxxxx; flags_in = 8'hxx;
    for (int k = 0; k < 5; k++) begin
      if (k > 0) @(negedge clk);
      chk({req, " strobes"}, {mem_rd, mem_wr, rf_we, flags_we, done, invalid}, exp_v[k]);
      if (k == 0 && !bad) chk({req, " R2 addr"}, mem_addr, ea);
      if (k == 2 && !bad && !test) begin
        chk({req, " R7 wdata"}, mem_wdata, res);
        chk({req, " R7 addr"}, mem_addr, ea);
        chk({req, " R8 sel"}, rf_sel, op[2:0]);
        chk({req, " R8 data"}, rf_data, res);
      end
      if (k == 2 && setfl) chk({req, " R5/R9 flags"}, flags_out, fl);
    end
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    repeat (2) @(negedge clk);
    chk("R12 reset strobes", {mem_rd, mem_wr, rf_we, flags_we, done, invalid}, 6'b0);
    rst_n = 1;
    @(negedge clk);
    chk("R12 after reset", {mem_rd, mem_wr, rf_we, flags_we, done, invalid}, 6'b0);
    // R3 shifts, each group
    run("R3 rlc", 16'h0100, 8'h05, 8'h00, 8'h00, 8'h81);
    run("R3 rrc", 16'h0100, 8'h06, 8'h09, 8'h00, 8'h01);
    run("R3 rl", 16'h0100, 8'h07, 8'h12, 8'h01, 8'h40);
    run("R3 rr", 16'h0100, 8'h08, 8'h1B, 8'h01, 8'h02);
    run("R3 sla", 16'h0100, 8'h09, 8'h24, 8'h00, 8'h80);
    run("R3 sra", 16'h0100, 8'h0A, 8'h2D, 8'h00, 8'h85);
    run("R3 srl", 16'h0100, 8'h0B, 8'h3F, 8'h00, 8'h01);
    run("R4 fill one", 16'h0100, 8'h0C, 8'h36, 8'h00, 8'h80);
    run("R4 fill one reg", 16'h0100, 8'h0D, 8'h37, 8'h00, 8'h7F);
    run("R5 parity", 16'h0100, 8'h0E, 8'h20, 8'h00, 8'h03);
    // R6 clear and set
    run("R6 clear bit7 to B", 16'h0200, 8'h10, 8'hB8, 8'h00, 8'hFF);
    run("R6 set bit3 mem only", 16'h0200, 8'h11, 8'hDE, 8'h00, 8'h00);
    run("R8 set bit0 to A", 16'h0200, 8'h12, 8'hC7, 8'h00, 8'h10);
    run("R8 clear bit2 to L", 16'h0200, 8'h13, 8'h95, 8'h00, 8'h04);
    // R9 bit test
    run("R9 test bit 0 zero", 16'h0300, 8'h01, 8'h46, 8'hA5, 8'hFE);
    run("R9 test bit 7 one", 16'h0300, 8'h02, 8'h7E, 8'h00, 8'h80);
    // R10 invalid
    run("R10 invalid 40", 16'h0300, 8'h03, 8'h40, 8'h00, 8'h55);
    run("R10 invalid 7F", 16'h0300, 8'h04, 8'h7F, 8'h00, 8'h55);
    // R2 wrap and negative displacement, R1 ordering implied by each run
    run("R2 wrap up", 16'hFFF0, 8'h20, 8'h38, 8'h00, 8'h10);
    run("R2 negative disp", 16'h0005, 8'hF0, 8'h00, 8'h00, 8'h01);
    run("R1 back to back", 16'h0005, 8'hF0, 8'h00, 8'h00, 8'h02);
    run("R11 done after flag", 16'h0300, 8'h05, 8'h5E, 8'h01, 8'h08);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule